// File: doc/BRIEF.md
# Dual-Standard FSK Tone Synthesizer

This block turns a serial stream of transmit bits into a sampled sine wave whose frequency carries the data. It supports two tone plans, one in the Bell 103 style and one in the V.21 style. Within each plan, an originate/answer select picks the band. One signed sample leaves the block on every clock while it is enabled, so the clock rate is the sample rate given by `SAMPLE_HZ`.

A 24-bit numerically controlled oscillator drives the tone. The block computes its eight step words at elaboration from the sample rate. A quarter-wave sine table, also computed at elaboration, turns the top phase bits into a 10-bit two's-complement sample. A change of data bit or of mode only swaps the step word, so the waveform never jumps in phase. Deasserting the enable parks the output at zero and rewinds the oscillator.

Top module: `fsk_tone_gen`

## Requirements
- R1: With `std_v21_i`=0 and `answer_i`=0, a bit of 1 produces 1270 Hz and a bit of 0 produces 1070 Hz.
- R2: With `std_v21_i`=0 and `answer_i`=1, a bit of 1 produces 2225 Hz and a bit of 0 produces 2025 Hz.
- R3: With `std_v21_i`=1 and `answer_i`=0, a bit of 1 produces 980 Hz and a bit of 0 produces 1180 Hz. In this case the mark tone is the lower one.
- R4: With `std_v21_i`=1 and `answer_i`=1, a bit of 1 produces 1650 Hz and a bit of 0 produces 1850 Hz.
- R5: A `tx_bit_i` of 1 always selects the mark tone and a 0 always selects the space tone of the current mode.
- R6: The phase step per clock is round(f x 2^24 / `SAMPLE_HZ`). The phase register is 24 bits wide and wraps modulo 2^24.
- R7: While `en_i` is high, each clock adds the step selected by the inputs at that edge to the phase. The phase is never reset when the bit or the mode changes.
- R8: On a clock with `en_i` low, the phase is cleared and `sample_o` becomes 0 after that edge. The first sample after re-enabling is taken at phase 0, which is the value 6.
- R9: On each enabled clock, `sample_o` takes the sine of the phase held before that edge, using the top 8 phase bits a[7:0]. Let k = a[5:0], mirrored to 63-k when a[6]=1. The magnitude is round(511 x sin((k+0.5) x pi/128)), and the sample is negated when a[7]=1.
- R10: While `rst_n` is low, and after its release until the first enabled clock, `sample_o` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| en_i | input | 1 | Runs the oscillator when high; clears it when low |
| std_v21_i | input | 1 | Tone plan: 0 = Bell 103 style, 1 = V.21 style |
| answer_i | input | 1 | Band: 0 = originate, 1 = answer |
| tx_bit_i | input | 1 | Data bit: 1 = mark, 0 = space |
| sample_o | output | 10 | Signed sine sample |

## Verification
A wrong step word, or a phase that is disturbed at a bit change, bends the sample sequence away from the reference oscillator. At the lower tones this is visible within a few samples, and it grows with every further clock because phase errors add up. A phase left behind after a disable shows in the very first sample after re-enabling, which must be 6. A sign or mirroring fault in the table shows within one quarter of a tone period as a sample with the wrong sign or a wrong magnitude.

// File: rtl/fsk_tone_pkg.sv
package fsk_tone_pkg;
  // Selector index: {std_v21, answer, bit}
  function automatic longint tone_hz(int sel);
    case (sel)
      0: return 1070;   // Bell org space
      1: return 1270;   // Bell org mark
      2: return 2025;   // Bell ans space
      3: return 2225;   // Bell ans mark
      4: return 1180;   // V.21 org space
      5: return 980;    // V.21 org mark
      6: return 1850;   // V.21 ans space
      default: return 1650; // V.21 ans mark
    endcase
  endfunction
endpackage

// File: rtl/fsk_step_sel.sv
module fsk_step_sel #(
  parameter int PHASE_W   = 24,
  parameter int SAMPLE_HZ = 9600
) (
  input  logic               std_v21_i,
  input  logic               answer_i,
  input  logic               tx_bit_i,
  output logic [PHASE_W-1:0] step_o
);
  import fsk_tone_pkg::*;

  localparam int NSEL = 8;

  function automatic longint step_of(longint f);
    return ((f << PHASE_W) + longint'(SAMPLE_HZ / 2)) / longint'(SAMPLE_HZ);
  endfunction

  logic [PHASE_W-1:0] steps [NSEL];

  for (genvar i = 0; i < NSEL; i++) begin : g_step
    assign steps[i] = PHASE_W'(step_of(tone_hz(i)));
  end

  logic [2:0] sel;
  assign sel    = {std_v21_i, answer_i, tx_bit_i};
  assign step_o = steps[sel];
endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
  parameter int PHASE_W = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_i,
  input  logic [PHASE_W-1:0] step_i,
  output logic [PHASE_W-1:0] phase_o
);
  logic [PHASE_W-1:0] phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (en_i) phase_d = phase_q + step_i;
    else      phase_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= '0;
    else        phase_q <= phase_d;
  end

  assign phase_o = phase_q;
endmodule

// File: rtl/fsk_sine_lut.sv
module fsk_sine_lut #(
  parameter int ADDR_W = 8,
  parameter int AMP_W  = 10
) (
  input  logic [ADDR_W-1:0]       addr_i,
  output logic signed [AMP_W-1:0] sample_o
);
  localparam int QA_W    = ADDR_W - 2;
  localparam int QN      = 1 << QA_W;
  localparam int MAG_W   = AMP_W - 1;
  localparam int AMP_MAX = (1 << MAG_W) - 1;

  function automatic int quarter_val(int k);
    real x, x2, s;
    x  = (real'(k) + 0.5) * 1.5707963267948966 / real'(QN);
    x2 = x * x;
    s  = x * (1.0 - x2 / 6.0 * (1.0 - x2 / 20.0 * (1.0 - x2 / 42.0 *
         (1.0 - x2 / 72.0 * (1.0 - x2 / 110.0)))));
    return $rtoi(s * real'(AMP_MAX) + 0.5);
  endfunction

  logic [MAG_W-1:0] quarter [QN];

  for (genvar k = 0; k < QN; k++) begin : g_quarter
    assign quarter[k] = MAG_W'(quarter_val(k));
  end

  logic [1:0]      quad;
  logic [QA_W-1:0] idx;
  logic [MAG_W-1:0] mag;
  logic signed [AMP_W-1:0] pos;

  always_comb begin
    quad = addr_i[ADDR_W-1 -: 2];
    idx  = quad[0] ? ~addr_i[QA_W-1:0] : addr_i[QA_W-1:0];
    mag  = quarter[idx];
    pos  = $signed({1'b0, mag});
    sample_o = quad[1] ? -pos : pos;
  end
endmodule

// File: rtl/fsk_tone_gen.sv
module fsk_tone_gen #(
  parameter int PHASE_W   = 24,
  parameter int LUT_W     = 8,
  parameter int AMP_W     = 10,
  parameter int SAMPLE_HZ = 9600
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    en_i,
  input  logic                    std_v21_i,
  input  logic                    answer_i,
  input  logic                    tx_bit_i,
  output logic signed [AMP_W-1:0] sample_o
);
  logic rst_meta_q, rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [PHASE_W-1:0] step_w;
  logic [PHASE_W-1:0] phase_q;
  logic signed [AMP_W-1:0] lut_w;
  logic signed [AMP_W-1:0] sample_q, sample_d;
  logic run;

  assign run = en_i & rst_sync_n;

  fsk_step_sel #(.PHASE_W(PHASE_W), .SAMPLE_HZ(SAMPLE_HZ)) u_sel (
    .std_v21_i(std_v21_i), .answer_i(answer_i), .tx_bit_i(tx_bit_i),
    .step_o(step_w));

  fsk_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
    .clk(clk), .rst_n(rst_sync_n), .en_i(run), .step_i(step_w),
    .phase_o(phase_q));

  fsk_sine_lut #(.ADDR_W(LUT_W), .AMP_W(AMP_W)) u_lut (
    .addr_i(phase_q[PHASE_W-1 -: LUT_W]), .sample_o(lut_w));

  always_comb begin
    sample_d = sample_q;
    if (run) sample_d = lut_w;
    else     sample_d = '0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) sample_q <= '0;
    else             sample_q <= sample_d;
  end

  assign sample_o = sample_q;
endmodule

// File: rtl/fsk_tone_gen_chk.sv
module fsk_tone_gen_chk #(
  parameter int PHASE_W = 24,
  parameter int AMP_W   = 10
) (
  input logic                    clk,
  input logic                    rst_sync_n,
  input logic                    en_i,
  input logic [PHASE_W-1:0]      step,
  input logic [PHASE_W-1:0]      phase,
  input logic signed [AMP_W-1:0] sample
);
  localparam int AMP_MAX = (1 << (AMP_W - 1)) - 1;

  AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_i |=> (sample == '0)); // R8
  AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !en_i |=> (phase == '0)); // R8
  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en_i |=> (phase == $past(phase) + $past(step))); // R7
  AST_STEP_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step != '0) && !step[PHASE_W-1]); // R6
  AST_SAMPLE_RANGE: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sample <= AMP_W'(AMP_MAX)) && (sample >= -AMP_W'(AMP_MAX))); // R9
  AST_SIGN_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_sync_n)
    en_i |=> (sample[AMP_W-1] == $past(phase[PHASE_W-1]))); // R9
endmodule

bind fsk_tone_gen fsk_tone_gen_chk #(.PHASE_W(PHASE_W), .AMP_W(AMP_W)) u_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .en_i(en_i), .step(step_w),
  .phase(phase_q), .sample(sample_o));

// File: tb/fsk_tone_gen_tb.sv
module fsk_tone_gen_tb;
  localparam int FS = 9600;

  logic clk, rst_n, en, stdv, ans, bitv;
  logic signed [9:0] sample;

  fsk_tone_gen #(.SAMPLE_HZ(FS)) u_dut (
    .clk(clk), .rst_n(rst_n), .en_i(en), .std_v21_i(stdv),
    .answer_i(ans), .tx_bit_i(bitv), .sample_o(sample));

  initial clk = 1'b0;
  always #5 clk = ~clk;

  int errors = 0, checks = 0;
  longint mphase = 0;
  int seg_bad = 0, seg_act = 0, seg_exp = 0;

  // {std, answer, bit, frequency}
  typedef struct packed { logic s; logic a; logic b; int f; } vec_t;
  localparam vec_t VECS [8] = '{
    '{1'b0, 1'b0, 1'b1, 1270}, '{1'b0, 1'b0, 1'b0, 1070},
    '{1'b0, 1'b1, 1'b1, 2225}, '{1'b0, 1'b1, 1'b0, 2025},
    '{1'b1, 1'b0, 1'b1, 980},  '{1'b1, 1'b0, 1'b0, 1180},
    '{1'b1, 1'b1, 1'b1, 1650}, '{1'b1, 1'b1, 1'b0, 1850}};

  function automatic int freq_of(logic s, logic a, logic b);
    if (!s) return a ? (b ? 2225 : 2025) : (b ? 1270 : 1070);
    return a ? (b ? 1650 : 1850) : (b ? 980 : 1180);
  endfunction

  function automatic longint step_of(int f);
    return ((longint'(f) << 24) + FS / 2) / FS;
  endfunction

  function automatic int sine_of(longint ph);
    int a, k, m;
    a = int'((ph >> 16) & 255);
    k = a & 63;
    if (a & 64) k = 63 - k;
    m = $rtoi(511.0 * $sin((real'(k) + 0.5) * 3.14159265358979 / 128.0) + 0.5);
    return (a & 128) ? -m : m;
  endfunction

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one clock; model updates from held inputs, compare at negedge
  task automatic step();
    int e;
    @(posedge clk);
    if (en) begin
      e = sine_of(mphase);
      mphase = (mphase + step_of(freq_of(stdv, ans, bitv))) & 64'hFFFFFF;
    end else begin
      e = 0;
      mphase = 0;
    end
    @(negedge clk);
    if ((int'(sample) - e > 1) || (e - int'(sample) > 1)) begin
      if (seg_bad == 0) begin seg_act = int'(sample); seg_exp = e; end
      seg_bad++;
    end
  endtask

  task automatic seg_start(); seg_bad = 0; endtask
  task automatic seg_end(string req);
    check(seg_bad == 0, req, seg_act, seg_exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; en = 1'b0; stdv = 1'b0; ans = 1'b0; bitv = 1'b1;
    repeat (3) @(negedge clk);
    check(sample == 0, "R10 reset", int'(sample), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(sample == 0, "R10 idle after release", int'(sample), 0);

    // Table walk: each mode and bit from phase 0 (R1..R6, R9)
    for (int v = 0; v < 8; v++) begin
      en = 1'b0; step();
      stdv = VECS[v].s; ans = VECS[v].a; bitv = VECS[v].b; en = 1'b1;
      seg_start();
      for (int c = 0; c < 60; c++) step();
      case (v / 2)
        0: seg_end(VECS[v].b ? "R1 R5 mark" : "R1 R5 space");
        1: seg_end(VECS[v].b ? "R2 R5 mark" : "R2 R5 space");
        2: seg_end(VECS[v].b ? "R3 R5 mark" : "R3 R5 space");
        default: seg_end(VECS[v].b ? "R4 R5 mark" : "R4 R5 space");
      endcase
    end

    // Long run checks step rounding by accumulated phase (R6)
    seg_start();
    stdv = 1'b1; ans = 1'b0; bitv = 1'b1;
    for (int c = 0; c < 3000; c++) step();
    seg_end("R6 long run");

    // Phase continuity across bit and mode changes (R7)
    seg_start();
    for (int c = 0; c < 40; c++) begin
      bitv = c[2]; stdv = c[4]; ans = c[3] ^ c[0];
      step();
    end
    seg_end("R7 continuity");

    // Disable then re-enable (R8)
    en = 1'b0; step();
    check(sample == 0, "R8 disable zero", int'(sample), 0);
    step();
    check(sample == 0, "R8 stays zero", int'(sample), 0);
    en = 1'b1; step();
    check(sample == 6, "R8 restart phase 0", int'(sample), 6);
    seg_start();
    for (int c = 0; c < 20; c++) step();
    seg_end("R8 R9 after restart");

    // Reset in mid-run (R10)
    rst_n = 1'b0; #1;
    check(sample == 0, "R10 async reset", int'(sample), 0);
    en = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(sample == 0, "R10 after reset", int'(sample), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule